// File: doc/BRIEF.md
# Configurable Input Port Controller

This block serves an 8-bit general-purpose input port. Every pin is configured on its own. The block gives software a direct read of the synchronised pin levels. Each pin can also be filtered by a slow-strobe debouncer, and each pin can raise a sticky interrupt flag on the edge it has selected.

The same filtered levels drive two system-level requests. The first is a wake pulse, produced when a wake-enabled pin shows its selected edge. The second is a reset request, raised when a programmed combination of pin levels holds for a programmed number of sample strobes. Pins marked as don't-care take no part in that comparison.

Pad drivers, pull resistors and open-drain drive are not part of this block. All configuration arrives as plain register-bit inputs.

Top module: `pin_port_ctl`

## Requirements
- R1: `pins_o` shows the raw pin levels two clock edges after they are applied, through a two-flop synchroniser. It is never filtered, even on pins whose debouncer is enabled.
- R2: A pin whose `edge_fall_i` bit is 0 sets its flag in `irq_flags_o` on a rising edge of its filtered level and ignores falling edges. Without debounce, the flag is visible three edges after the pin changes.
- R3: A pin whose `edge_fall_i` bit is 1 sets its flag on a falling edge of its filtered level and ignores rising edges.
- R4: A flag can only become set while its `irq_en_i` bit is 1. `irq_o` is 1 exactly when any flag is set.
- R5: Flags are sticky. A 1 on an `irq_clr_i` bit clears that flag one edge later. If a new edge on the same pin arrives in the same cycle as the clear, the new edge wins and the flag stays set.
- R6: With debounce enabled on a pin, a new level is accepted only at the second consecutive `sample_i` strobe that sees that level. A level that is present at only one strobe causes no flag.
- R7: `wake_o` is a one-cycle pulse. It is raised in the cycle a selected edge is registered on a pin whose `wake_en_i` bit is 1, whatever that pin's `irq_en_i` bit is.
- R8: With `rst_en_i` at 1, `reset_req_o` rises right after the `rst_len_i`-th consecutive strobe at which the filtered pins match the pattern. A length of 0 acts as 1.
- R9: Pins with a 0 in `rst_mask_i` are don't-care. Their levels neither break nor make the match against `rst_pat_i`.
- R10: A mismatch in any cycle restarts the strobe count and drops `reset_req_o` at once. With `rst_en_i` at 0, `reset_req_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | 8 | Asynchronous pin levels |
| sample_i | input | 1 | One-cycle slow sample strobe |
| deb_en_i | input | 8 | Per-pin debounce enable |
| edge_fall_i | input | 8 | Per-pin edge select: 1 = falling, 0 = rising |
| irq_en_i | input | 8 | Per-pin interrupt enable |
| irq_clr_i | input | 8 | Write-1-to-clear pulses for the flags |
| wake_en_i | input | 8 | Per-pin wake enable |
| rst_en_i | input | 1 | Combination reset enable |
| rst_mask_i | input | 8 | Per-pin compare enable (0 = don't care) |
| rst_pat_i | input | 8 | Level pattern for the combination reset |
| rst_len_i | input | 8 | Number of consecutive matching strobes required |
| pins_o | output | 8 | Direct (synchronised, unfiltered) pin read |
| irq_flags_o | output | 8 | Sticky interrupt flags |
| irq_o | output | 1 | OR of all flags |
| wake_o | output | 1 | Wake request pulse |
| reset_req_o | output | 1 | System reset request |

## Verification
Timing is counted from the edge at which a pin change is applied:
- The direct read is due two edges later.
- Without debounce, flags and wake pulses are due three edges later. A clear lands one edge after its pulse.
- With debounce, a flag is due one edge after the second agreeing strobe.
- The reset request moves in the cycle after the deciding strobe, and falls as soon as the synchronised mismatch appears.

The bench samples one time unit after the due edge. It checks the same output again one cycle later where a pulse or an ignored edge must be seen to stay absent. Every pin is swept under both edge polarities, and the accumulated flag vector is computed by shifting.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;
  parameter int unsigned PORT_W = 8;
  parameter int unsigned LEN_W  = 8;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pin_debounce.sv
module pin_debounce #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sample_i,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] samp_q, stable_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        samp_q[i]   <= 1'b0;
        stable_q[i] <= 1'b0;
      end else if (sample_i) begin
        samp_q[i] <= raw_i[i];
        // accept only when two successive strobes agree
        if (samp_q[i] == raw_i[i]) stable_q[i] <= raw_i[i];
      end
    end
    assign lvl_o[i] = en_i[i] ? stable_q[i] : raw_i[i];
  end

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(stable_q));
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] fall_i,
  input  logic [W-1:0] irq_en_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] wake_en_i,
  output logic [W-1:0] flags_o,
  output logic         wake_o
);
  logic [W-1:0] prev_q, flags_q, ev;
  logic         wake_q;

  assign ev = (fall_i & ~lvl_i & prev_q) | (~fall_i & lvl_i & ~prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      flags_q <= '0;
      wake_q  <= 1'b0;
    end else begin
      prev_q  <= lvl_i;
      // a new edge beats a clear in the same cycle
      flags_q <= (flags_q & ~clr_i) | (ev & irq_en_i);
      wake_q  <= |(ev & wake_en_i);
    end
  end

  assign flags_o = flags_q;
  assign wake_o  = wake_q;

  assert_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(irq_en_i)) == '0));
  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_q & $past(clr_i & ~ev)) == '0));
endmodule

// File: rtl/pin_combo_reset.sv
module pin_combo_reset #(
  parameter int unsigned W     = 8,
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic [W-1:0]     lvl_i,
  input  logic             en_i,
  input  logic [W-1:0]     mask_i,
  input  logic [W-1:0]     pat_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             req_o
);
  localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] cnt_q;
  logic             match;

  assign match = en_i && (((lvl_i ^ pat_i) & mask_i) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!match)                      cnt_q <= '0;
    else if (sample_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // a length of zero behaves as one
  assign req_o = match && (cnt_q != '0) && (cnt_q >= len_i);

  assert_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !req_o);
  assert_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match |=> (cnt_q == '0));
endmodule

// File: rtl/pin_port_ctl.sv
module pin_port_ctl
  import pin_port_pkg::*;
#(
  parameter int unsigned W     = PORT_W,
  parameter int unsigned LEN_W = pin_port_pkg::LEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     pins_i,
  input  logic             sample_i,
  input  logic [W-1:0]     deb_en_i,
  input  logic [W-1:0]     edge_fall_i,
  input  logic [W-1:0]     irq_en_i,
  input  logic [W-1:0]     irq_clr_i,
  input  logic [W-1:0]     wake_en_i,
  input  logic             rst_en_i,
  input  logic [W-1:0]     rst_mask_i,
  input  logic [W-1:0]     rst_pat_i,
  input  logic [LEN_W-1:0] rst_len_i,
  output logic [W-1:0]     pins_o,
  output logic [W-1:0]     irq_flags_o,
  output logic             irq_o,
  output logic             wake_o,
  output logic             reset_req_o
);
  logic [W-1:0] sync_lvl, filt_lvl;

  pin_sync #(.W(W)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_i), .q_o(sync_lvl)
  );

  pin_debounce #(.W(W)) u_deb (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i),
    .raw_i(sync_lvl), .en_i(deb_en_i), .lvl_o(filt_lvl)
  );

  pin_edge_irq #(.W(W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(filt_lvl), .fall_i(edge_fall_i),
    .irq_en_i(irq_en_i), .clr_i(irq_clr_i), .wake_en_i(wake_en_i),
    .flags_o(irq_flags_o), .wake_o(wake_o)
  );

  pin_combo_reset #(.W(W), .LEN_W(LEN_W)) u_combo (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .lvl_i(filt_lvl),
    .en_i(rst_en_i), .mask_i(rst_mask_i), .pat_i(rst_pat_i), .len_i(rst_len_i),
    .req_o(reset_req_o)
  );

  assign pins_o = sync_lvl;
  assign irq_o  = |irq_flags_o;

  assert_irq_or_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flags_o == '0) |-> !irq_o);
endmodule

// File: tb/pin_port_ctl_test.sv
`timescale 1ns/1ps
module pin_port_ctl_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pins = '0, deb_en = '0, edge_fall = '0, irq_en = '0, irq_clr = '0;
  logic [7:0] wake_en = '0, rst_mask = '0, rst_pat = '0, rst_len = '0;
  logic       sample = 1'b0, rst_en = 1'b0;
  logic [7:0] pins_o, flags_o;
  logic       irq_o, wake_o, req_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pin_port_ctl uut (
    .clk_i(clk), .rst_ni(rst_ni), .pins_i(pins), .sample_i(sample),
    .deb_en_i(deb_en), .edge_fall_i(edge_fall), .irq_en_i(irq_en),
    .irq_clr_i(irq_clr), .wake_en_i(wake_en), .rst_en_i(rst_en),
    .rst_mask_i(rst_mask), .rst_pat_i(rst_pat), .rst_len_i(rst_len),
    .pins_o(pins_o), .irq_flags_o(flags_o), .irq_o(irq_o), .wake_o(wake_o),
    .reset_req_o(req_o)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe();
    sample = 1'b1;
    step(1);
    sample = 1'b0;
  endtask

  task automatic clear_all();
    irq_clr = 8'hFF;
    step(1);
    irq_clr = '0;
    step(1);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] exp;
    logic [7:0] idle;
    step(3);
    rst_ni = 1'b1;
    step(1);
    chk("reset flags", flags_o, 0);
    chk("reset wake", wake_o, 0);
    chk("reset req", req_o, 0);
    chk("reset irq", irq_o, 0);

    // R1: direct read latency of two edges
    pins = 8'h3C;
    step(1);
    chk("R1 not yet", pins_o, 8'h00);
    step(1);
    chk("R1 direct read", pins_o, 8'h3C);
    pins = 8'h00;
    step(3);
    clear_all();

    // R2 / R3 sweep over every pin and both polarities
    irq_en = 8'hFF;
    for (int pol = 0; pol < 2; pol++) begin
      idle = (pol == 1) ? 8'hFF : 8'h00;
      edge_fall = idle;
      pins = idle;
      step(4);
      clear_all();
      exp = '0;
      for (int b = 0; b < 8; b++) begin
        pins = idle ^ (8'h01 << b);
        step(3);
        exp = exp | (8'h01 << b);
        chk(pol ? "R3 falling edge sets flag" : "R2 rising edge sets flag", flags_o, exp);
        pins = idle;
        step(3);
        chk(pol ? "R3 rising edge ignored" : "R2 falling edge ignored", flags_o, exp);
      end
    end
    edge_fall = '0;
    pins = '0;
    step(4);
    clear_all();

    // R4: enable mask and irq OR
    irq_en = 8'h0F;
    pins = 8'hFF;
    step(3);
    chk("R4 masked flags", flags_o, 8'h0F);
    chk("R4 irq_o set", irq_o, 1);
    clear_all();
    chk("R4 irq_o clear", irq_o, 0);
    pins = 8'h00;
    step(4);
    chk("R4 disabled pins stay clear", flags_o, 8'h00);

    // R5: clear and set-wins
    irq_en = 8'hFF;
    pins = 8'h01;
    step(3);
    chk("R5 sticky set", flags_o, 8'h01);
    step(5);
    chk("R5 sticky hold", flags_o, 8'h01);
    irq_clr = 8'h01;
    step(1);
    irq_clr = '0;
    chk("R5 write one clears", flags_o, 8'h00);
    pins = 8'h00;
    step(3);
    pins = 8'h02;
    step(2);
    irq_clr = 8'h02;
    step(1);
    irq_clr = '0;
    chk("R5 set wins over clear", flags_o, 8'h02);
    pins = 8'h00;
    step(4);
    clear_all();

    // R6: debounce
    deb_en = 8'hFF;
    strobe(); strobe();
    step(2);
    clear_all();
    pins = 8'h10;
    step(3);
    chk("R1 raw under debounce", pins_o, 8'h10);
    chk("R6 no flag before strobes", flags_o, 8'h00);
    strobe();
    step(1);
    chk("R6 one strobe not enough", flags_o, 8'h00);
    strobe();
    step(1);
    chk("R6 accepted at second strobe", flags_o, 8'h10);
    clear_all();
    pins = 8'h30;
    step(3);
    strobe();
    pins = 8'h10;
    step(3);
    strobe();
    step(1);
    strobe();
    step(1);
    chk("R6 glitch ignored", flags_o, 8'h00);
    deb_en = '0;
    pins = 8'h00;
    step(4);
    clear_all();

    // R7: wake pulse, independent of irq enable
    irq_en = 8'h00;
    wake_en = 8'h08;
    pins = 8'h08;
    step(2);
    chk("R7 no wake early", wake_o, 0);
    step(1);
    chk("R7 wake pulse", wake_o, 1);
    step(1);
    chk("R7 wake one cycle", wake_o, 0);
    pins = 8'h0C;
    step(3);
    chk("R7 non-wake pin", wake_o, 0);
    chk("R7 irq disabled no flag", flags_o, 8'h00);
    wake_en = '0;
    irq_en = 8'hFF;
    pins = 8'h00;
    step(4);
    clear_all();

    // R8 / R9 / R10: combination reset, mask 0x0F pattern 0x05 length 3
    rst_mask = 8'h0F;
    rst_pat = 8'h05;
    rst_len = 8'd3;
    pins = 8'hA5;
    step(3);
    strobe(); strobe();
    chk("R10 disabled no request", req_o, 0);
    rst_en = 1'b1;
    step(1);
    strobe(); strobe();
    chk("R8 two strobes short", req_o, 0);
    strobe();
    chk("R8 request after third", req_o, 1);
    pins = 8'h55;
    step(3);
    chk("R9 dont-care bits ignored", req_o, 1);
    pins = 8'h54;
    step(2);
    chk("R10 mismatch drops request", req_o, 0);
    pins = 8'h05;
    step(3);
    strobe(); strobe();
    chk("R10 count restarted", req_o, 0);
    strobe();
    chk("R8 request again", req_o, 1);
    rst_en = 1'b0;
    step(1);
    chk("R10 disable clears", req_o, 0);
    rst_en = 1'b1;
    rst_len = 8'd0;
    step(1);
    chk("R8 zero length no strobe yet", req_o, 0);
    strobe();
    chk("R8 zero length acts as one", req_o, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule